// File: doc/BRIEF.md
# Burst-Addressed SPI Register Slave

This block is a serial slave that gives an SPI master (mode 0: clock idles low, data sampled on the rising edge) access to a file of 16-bit registers addressed from 0x00 to 0x73. A transaction opens when chip-select falls. The first byte carries the register address and a direction flag. After that byte, any number of 16-bit words are read or written, most significant bit first. After each word the address moves on by itself, so one chip-select period can cover a run of registers.

Two stepping schemes exist, and a bit of the control register at 0x10 chooses between them. With the bit clear, the address simply counts up. With the bit set, the address can skip inside two register ranges. A burst read that starts in the analog-input result range (0x40 plus port index) jumps to the next port flagged in an input mask. A burst write that starts in the analog-output value range (0x60 plus port index) jumps to the next port flagged in an output mask. The two per-port masks come from outside the block.

The SPI pins are oversampled by the system clock, so the block has one clock domain. Register 0x00 is a fixed identifier. The other registers only store what is written to them.

Top module: `spi_ctx_regs`

## Requirements
- R1: The first byte of a transaction is sent MSB first. Its bits 7:1 hold the register address and its bit 0 the direction (1 = read, 0 = write).
- R2: Each data word is 16 bits, MSB first. A written word is stored in the addressed register when its 16th bit is sampled. A read returns the register's current value.
- R3: A read of address 0x00 returns 0x0424. Writes to 0x00 have no effect.
- R4: A read of any address above 0x73 returns 0x0000. Writes to those addresses have no effect.
- R5: When bit 14 of register 0x10 is 0, the address increases by one after every word, wrapping from 0x7F to 0x00.
- R6: When bit 14 of register 0x10 is 1, a read word at address 0x40+i (i below the port count) is followed by address 0x40+j. Here j is the smallest index above i with bit j of the input mask set. If no such index exists, the next address is 0x40 plus the port count.
- R7: When bit 14 of register 0x10 is 1, a write word at address 0x60+i is followed by address 0x60+j. Here j is the smallest index above i with bit j of the output mask set. If no such index exists, the next address is 0x60 plus the port count.
- R8: With bit 14 of register 0x10 set, all other cases still step by one. This covers reads in the 0x60 range, writes in the 0x40 range, and every other address.
- R9: A word cut short by chip-select rising is discarded. The next transaction starts again with a new address byte.
- R10: The MISO value changes only one system clock after a detected SCLK falling edge, and is 0 outside a transaction. The output-enable is high exactly while chip-select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip-select, active low |
| sclk | input | 1 | SPI clock, idles low |
| mosi | input | 1 | Serial data from master |
| adc_port_mask | input | NPORTS | Per-port flag: port is an analog input |
| dac_port_mask | input | NPORTS | Per-port flag: port is an analog output |
| miso | output | 1 | Serial data to master |
| miso_oe | output | 1 | Drive enable for miso; low means high impedance |

## Verification
The bench builds the block with its default parameters: 20 ports, a 7-bit address and 16-bit words. This places both skipping ranges inside the legal address space. It also puts the past-the-end addresses 0x54 and 0x74 on either side of the 0x73 limit, so the "no further port" case of R6 lands on a stored register while that of R7 lands on an ignored address. Randomized masks and bursts that cross the 0x7F wrap and the range edges cover the mix of stepping rules. These are checked against a bench-side register model.

// File: rtl/spi_ctx_regs.sv
module spi_ctx_regs #(
  parameter int NPORTS = 20,
  parameter int AW = 7,
  parameter int DW = 16,
  parameter logic [AW-1:0] MAX_ADDR = 7'h73,
  parameter logic [DW-1:0] ID_VALUE = 16'h0424,
  parameter logic [AW-1:0] CTRL_ADDR = 7'h10,
  parameter int CTX_BIT = 14,
  parameter logic [AW-1:0] ADC_BASE = 7'h40,
  parameter logic [AW-1:0] DAC_BASE = 7'h60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              mosi,
  input  logic [NPORTS-1:0] adc_port_mask,
  input  logic [NPORTS-1:0] dac_port_mask,
  output logic              miso,
  output logic              miso_oe
);
  localparam int BW = $clog2(DW);
  localparam int ADC_END = int'(ADC_BASE) + NPORTS;
  localparam int DAC_END = int'(DAC_BASE) + NPORTS;

  logic [DW-1:0] mem [1:MAX_ADDR];
  logic          sclk_q, hdr_done, rd, miso_r;
  logic [BW-1:0] bcnt;
  logic [DW-2:0] sh;
  logic [DW-1:0] tx, ctrl_reg;
  logic [AW-1:0] addr, nxt;
  logic          rise, fall, hdr_end, word_done, ctx, in_adc, in_dac;

  assign rise      = ~cs_n & sclk & ~sclk_q;
  assign fall      = ~cs_n & ~sclk & sclk_q;
  assign hdr_end   = rise & ~hdr_done & (bcnt == BW'(AW));
  assign word_done = rise & hdr_done & (bcnt == BW'(DW-1));
  assign ctrl_reg  = mem[CTRL_ADDR];
  assign ctx       = ctrl_reg[CTX_BIT];
  assign in_adc    = int'(addr) >= int'(ADC_BASE) && int'(addr) < ADC_END;
  assign in_dac    = int'(addr) >= int'(DAC_BASE) && int'(addr) < DAC_END;
  assign miso      = miso_r;
  assign miso_oe   = ~cs_n;

  function automatic logic [DW-1:0] rdval(input logic [AW-1:0] a);
    if (a == '0) return ID_VALUE;
    if (a > MAX_ADDR) return '0;
    return mem[a];
  endfunction

  function automatic logic [AW-1:0] next_port(input logic [AW-1:0] base, input int idx,
                                              input logic [NPORTS-1:0] mask);
    int r = NPORTS;
    for (int j = NPORTS - 1; j >= 0; j--)
      if (j > idx && mask[j]) r = j;
    return AW'(int'(base) + r);
  endfunction

  always_comb begin
    if (ctx && rd && in_adc)
      nxt = next_port(ADC_BASE, int'(addr) - int'(ADC_BASE), adc_port_mask);
    else if (ctx && !rd && in_dac)
      nxt = next_port(DAC_BASE, int'(addr) - int'(DAC_BASE), dac_port_mask);
    else
      nxt = addr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      hdr_done <= 1'b0;
      rd       <= 1'b0;
      miso_r   <= 1'b0;
      bcnt     <= '0;
      sh       <= '0;
      tx       <= '0;
      addr     <= '0;
      for (int i = 1; i <= int'(MAX_ADDR); i++) mem[i] <= '0;
    end else begin
      sclk_q <= sclk;
      if (cs_n) begin
        hdr_done <= 1'b0;
        bcnt     <= '0;
        tx       <= '0;
        miso_r   <= 1'b0;
      end else begin
        if (rise) begin
          sh   <= {sh[DW-3:0], mosi};
          bcnt <= bcnt + 1'b1;
        end
        if (hdr_end) begin
          addr     <= sh[AW-1:0];
          rd       <= mosi;
          hdr_done <= 1'b1;
          bcnt     <= '0;
          tx       <= mosi ? rdval(sh[AW-1:0]) : '0;
        end
        if (word_done) begin
          bcnt <= '0;
          addr <= nxt;
          tx   <= rd ? rdval(nxt) : '0;
          if (!rd && addr != '0 && addr <= MAX_ADDR) mem[addr] <= {sh, mosi};
        end
        if (fall) begin
          miso_r <= tx[DW-1];
          tx     <= {tx[DW-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_ctx_regs_chk.sv
module spi_ctx_regs_chk #(
  parameter int NPORTS = 20,
  parameter int AW = 7,
  parameter int DW = 16,
  parameter logic [AW-1:0] CTRL_ADDR = 7'h10,
  parameter logic [AW-1:0] ADC_BASE = 7'h40,
  parameter int BW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sclk,
  input logic              miso,
  input logic              hdr_done,
  input logic [BW-1:0]     bcnt,
  input logic              rd,
  input logic              word_done,
  input logic              ctx,
  input logic [AW-1:0]     addr,
  input logic [DW-1:0]     ctrl_reg,
  input logic [NPORTS-1:0] adc_port_mask
);
  localparam int ADC_END = int'(ADC_BASE) + NPORTS;
  logic in_adc;
  assign in_adc = int'(addr) >= int'(ADC_BASE) && int'(addr) < ADC_END;

  AST_CTRL_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_reg != $past(ctrl_reg)) |-> $past(word_done && !rd && addr == CTRL_ADDR)); // R2
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !ctx) |=> (addr == $past(addr) + 1'b1)); // R5
  AST_CTX_ADC_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && ctx && rd && in_adc) |=>
      (addr > $past(addr)) && ((int'(addr) >= ADC_END) || adc_port_mask[int'(addr) - int'(ADC_BASE)])); // R6
  AST_PARTIAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> (!hdr_done && bcnt == '0)); // R9
  AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !(!$past(sclk) && $past(sclk, 2))) |-> $stable(miso)); // R10
endmodule

bind spi_ctx_regs spi_ctx_regs_chk #(
  .NPORTS(NPORTS), .AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR), .ADC_BASE(ADC_BASE), .BW(BW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .miso(miso),
  .hdr_done(hdr_done), .bcnt(bcnt), .rd(rd), .word_done(word_done), .ctx(ctx),
  .addr(addr), .ctrl_reg(ctrl_reg), .adc_port_mask(adc_port_mask)
);

// File: tb/sim_spi_ctx_regs.sv
module sim_spi_ctx_regs;
  localparam int N = 20;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic [N-1:0] adcm = '0, dacm = '0;
  logic miso, miso_oe;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [15:0] model [0:127];
  logic [15:0] wbuf [0:31];
  logic [15:0] rbuf [0:31];

  always #2 clk = ~clk;

  spi_ctx_regs u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .adc_port_mask(adcm), .dac_port_mask(dacm), .miso(miso), .miso_oe(miso_oe));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m_rd(input logic [6:0] a);
    if (a == 7'h00) return 16'h0424;
    if (a > 7'h73) return 16'h0000;
    return model[a];
  endfunction

  function automatic logic [6:0] m_next(input logic [6:0] a, input logic r);
    int k;
    logic c = model[7'h10][14];
    if (c && r && a >= 7'h40 && a < 7'h40 + N) begin
      k = a - 7'h40 + 1;
      while (k < N && !adcm[k]) k++;
      return 7'(7'h40 + k);
    end
    if (c && !r && a >= 7'h60 && a < 7'h60 + N) begin
      k = a - 7'h60 + 1;
      while (k < N && !dacm[k]) k++;
      return 7'(7'h60 + k);
    end
    return a + 7'd1;
  endfunction

  task automatic sbit(input logic b, output logic o);
    @(negedge clk) mosi = b;
    repeat (3) @(negedge clk);
    o = miso;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic xfer(input logic r, input logic [6:0] a, input int nw, input int tail);
    logic o;
    logic [7:0] h = {a, r};
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 7; i >= 0; i--) sbit(h[i], o);
    for (int w = 0; w < nw; w++)
      for (int i = 15; i >= 0; i--) begin
        sbit(wbuf[w][i], o);
        rbuf[w][i] = o;
      end
    for (int i = 0; i < tail; i++) sbit(1'b1, o);
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run(input string tag, input logic r, input logic [6:0] a, input int nw);
    logic [6:0] p = a, q;
    xfer(r, a, nw, 0);
    for (int w = 0; w < nw; w++) begin
      q = m_next(p, r);
      if (r) chk(tag, rbuf[w], m_rd(p));
      else if (p != 7'h00 && p <= 7'h73) model[p] = wbuf[w];
      p = q;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20251));
    for (int i = 0; i < 128; i++) model[i] = 16'h0000;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 reset oe", {15'd0, miso_oe}, 16'd0);
    chk("R10 reset miso", {15'd0, miso}, 16'd0);

    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 oe while selected", {15'd0, miso_oe}, 16'd1);
    @(negedge clk) cs_n = 1'b1;
    repeat (2) @(negedge clk);

    run("R1 R3 id read", 1'b1, 7'h00, 1);
    wbuf[0] = 16'hFFFF;
    run("R3 id write", 1'b0, 7'h00, 1);
    run("R3 id after write", 1'b1, 7'h00, 1);

    wbuf[0] = 16'h1000;
    run("R2 write cfg", 1'b0, 7'h25, 1);
    run("R2 readback cfg", 1'b1, 7'h25, 1);

    for (int i = 0; i < 32; i++) wbuf[i] = 16'hA500 + 16'(i * 7);
    run("R5 linear write", 1'b0, 7'h40, 21);
    run("R5 linear read", 1'b1, 7'h3E, 24);
    run("R4 R5 wrap read", 1'b1, 7'h7E, 3);
    wbuf[0] = 16'h5A5A;
    run("R4 write high", 1'b0, 7'h75, 1);
    run("R4 read high", 1'b1, 7'h75, 1);

    wbuf[0] = 16'h4000;
    run("R5 ctx on", 1'b0, 7'h10, 1);
    adcm = N'(32'h0008_0024);
    dacm = N'(32'h0004_0102);
    run("R6 ctx adc read", 1'b1, 7'h40, 4);
    run("R6 ctx adc from unflagged", 1'b1, 7'h43, 3);
    for (int i = 0; i < 32; i++) wbuf[i] = 16'h3C00 + 16'(i * 3);
    run("R8 ctx adc write linear", 1'b0, 7'h44, 5);
    run("R8 ctx adc readback", 1'b1, 7'h3F, 8);
    run("R7 ctx dac write", 1'b0, 7'h60, 4);
    run("R7 R8 dac read linear", 1'b1, 7'h60, 20);
    run("R8 ctx other linear", 1'b1, 7'h24, 3);

    wbuf[0] = 16'hBEEF;
    run("R9 setup", 1'b0, 7'h30, 1);
    for (int i = 0; i < 32; i++) wbuf[i] = 16'h0123;
    xfer(1'b0, 7'h30, 0, 9);
    run("R9 partial word dropped", 1'b1, 7'h30, 1);
    xfer(1'b0, 7'h30, 1, 0);
    wbuf[0] = 16'h0000;
    xfer(1'b0, 7'h31, 0, 3);
    model[7'h30] = 16'h0123;
    run("R9 fresh header after drop", 1'b1, 7'h30, 1);

    for (int t = 0; t < 60; t++) begin
      logic r = 1'($urandom);
      logic [6:0] a = 7'($urandom);
      int nw = 1 + int'($urandom % 6);
      adcm = N'($urandom);
      dacm = N'($urandom);
      if (t % 7 == 0) a = (t % 2 == 0) ? 7'h40 + 7'($urandom % N) : 7'h60 + 7'($urandom % N);
      for (int i = 0; i < 32; i++) wbuf[i] = 16'($urandom);
      if (a == 7'h10) wbuf[0][14] = 1'($urandom);
      run("R2 R6 R7 random", r, a, nw);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule